// File: doc/BRIEF.md
# Squaring Sample-Power Integrator

This block estimates total signal power from a stream of signed ADC samples. Each qualified sample is squared by a radix-4 recoded multiplier whose two operands are both the sample. The square is then added into a wide running sum. Once a programmable number of qualified samples has been summed, the block hands the total to a held output register, pulses a one-cycle result strobe and begins the next window with an empty sum.

The running sum is split in two. A narrow carry-lookahead adder updates the low bits on every qualified sample. Its carry-out increments a counter that holds the high bits. If that counter would wrap, the sum sticks at all ones for the rest of the window, and the result is flagged as overflowed. Dropping the enable input or pulsing the synchronous clear abandons the window in progress, and no result is produced for it.

Top module: `pwr_integrator`

## Requirements
- R1: While reset is asserted and after its release, `pwr_word`, `pwr_valid` and `ovf_flag` are all zero until the first result.
- R2: A window's result equals the sum of the squares of its samples, where each sample on `smp_data` is read as a two's complement value in the range -32 to +31.
- R3: Only cycles with `smp_valid` and `enable` both high contribute a sample. Other cycles neither add to the sum nor advance the window count.
- R4: `pwr_valid` is high for exactly one cycle per completed window. It becomes visible after the second rising edge, counting from the edge that samples the window's last sample.
- R5: Windows follow one another with no gap. The first qualified sample after a window's last sample starts the next window, so no sample is lost or counted twice.
- R6: The window length is taken from `win_len` when the block leaves its idle state and again on the edge that closes each window. A change in mid-window applies from the next window.
- R7: If the sum of a window would exceed the largest value the sum can hold, the result is all ones and `ovf_flag` is 1 with that result. The following window starts clean.
- R8: When `enable` is low on a clock edge, the open window and any square in flight are discarded, and `pwr_valid` is low after that edge.
- R9: When `clr` is high on a clock edge, it acts the same way as a low `enable`.
- R10: `pwr_word` and `ovf_flag` change only together with a `pwr_valid` pulse. Between results they hold their value.
- R11: A `win_len` of zero selects the length given by the `DEFAULT_WIN` parameter (20,000,000 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; abandons the current window |
| enable | input | 1 | Integration enable; low abandons the window and idles |
| smp_valid | input | 1 | Qualifier for `smp_data` |
| smp_data | input | SMP_W (6) | Signed two's complement sample |
| win_len | input | LEN_W (32) | Samples per window; zero selects `DEFAULT_WIN` |
| pwr_word | output | LO_W+HI_W (32) | Latched sum of squares of the last window |
| pwr_valid | output | 1 | One-cycle strobe when `pwr_word` is updated |
| ovf_flag | output | 1 | The last result saturated |

## Verification
The embedded properties watch the things that hold on every edge. A dropped enable or a clear always silences the strobe on the next edge. No square reaches the adder while the controller is idle. An unqualified input never produces a qualified square. Every strobe has a qualified square behind it. An overflowed result always reads all ones, and the output word never moves without a strobe. The bench's scenarios are the only place where the arithmetic of the Booth squarer, the carry between the low adder and the high counter, the window-length sampling points, seamless back-to-back windows, saturation across many samples and the default length are checked. They do this against a behavioural model.

// File: rtl/pwri_pkg.sv
package pwri_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pwri_state_e;
endpackage

// File: rtl/pwri_cla.sv
module pwri_cla #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  // W must be a multiple of 4; carries look ahead inside each nibble
  localparam int NBLK = W / 4;

  logic [NBLK:0] bc;
  logic [W-1:0]  c;

  assign bc[0] = cin;

  genvar k;
  generate
    for (k = 0; k < NBLK; k++) begin : g_blk
      logic [3:0] g;
      logic [3:0] p;
      assign g = a[4*k+3:4*k] & b[4*k+3:4*k];
      assign p = a[4*k+3:4*k] ^ b[4*k+3:4*k];
      assign c[4*k]   = bc[k];
      assign c[4*k+1] = g[0] | (p[0] & bc[k]);
      assign c[4*k+2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & bc[k]);
      assign c[4*k+3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                      | (p[2] & p[1] & p[0] & bc[k]);
      assign bc[k+1]  = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                      | (p[3] & p[2] & p[1] & g[0]) | ((&p) & bc[k]);
    end
  endgenerate

  assign sum  = a ^ b ^ c;
  assign cout = bc[NBLK];
endmodule

// File: rtl/pwri_squarer.sv
module pwri_squarer #(
  parameter int SMP_W = 6,
  parameter int SQ_W  = 2 * SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_data,
  output logic             sq_valid,
  output logic [SQ_W-1:0]  sq_data
);
  localparam int NDIG = (SMP_W + 1) / 2;

  logic signed [SQ_W-1:0] a_ext;
  logic signed [SQ_W-1:0] pp;
  logic signed [SQ_W-1:0] prod;
  logic [2*NDIG:0]        rec;

  // radix-4 recoding, multiplier and multiplicand are the same sample
  always_comb begin
    a_ext = {{(SQ_W-SMP_W){in_data[SMP_W-1]}}, in_data};
    rec   = {a_ext[2*NDIG-1:0], 1'b0};
    prod  = '0;
    for (int i = 0; i < NDIG; i++) begin
      case (rec[2*i +: 3])
        3'b001, 3'b010: pp = a_ext;
        3'b011:         pp = a_ext <<< 1;
        3'b100:         pp = -(a_ext <<< 1);
        3'b101, 3'b110: pp = -a_ext;
        default:        pp = '0;
      endcase
      prod = prod + (pp <<< (2 * i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_valid <= 1'b0;
      sq_data  <= '0;
    end else begin
      sq_valid <= in_valid & ~flush;
      if (in_valid && !flush) begin
        sq_data <= prod;
      end
    end
  end

  // R3
  no_unqualified_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !sq_valid);
endmodule

// File: rtl/pwri_ctrl.sv
module pwri_ctrl
  import pwri_pkg::*;
#(
  parameter int          LEN_W       = 32,
  parameter int unsigned DEFAULT_WIN = 20_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enable,
  input  logic             sq_valid,
  input  logic [LEN_W-1:0] win_len,
  output logic             flush,
  output logic             close
);
  pwri_state_e      state_q, state_d;
  logic [LEN_W-1:0] win_q, win_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] eff_len;

  assign flush   = clr | ~enable;
  assign eff_len = (win_len == '0) ? LEN_W'(DEFAULT_WIN) : win_len;
  assign close   = (state_q == ST_RUN) && sq_valid && (cnt_q == win_q - LEN_W'(1));

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    cnt_d   = cnt_q;
    if (flush) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (state_q == ST_IDLE) begin
      state_d = ST_RUN;
      win_d   = eff_len;
      cnt_d   = '0;
    end else if (sq_valid) begin
      if (close) begin
        win_d = eff_len;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      cnt_q   <= cnt_d;
    end
  end

  // R8
  idle_no_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sq_valid);
endmodule

// File: rtl/pwri_accum.sv
module pwri_accum #(
  parameter int LO_W = 12,
  parameter int HI_W = 20,
  parameter int SQ_W = 12,
  localparam int SUM_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             add_en,
  input  logic             close,
  input  logic [SQ_W-1:0]  addend,
  output logic [SUM_W-1:0] pwr_word,
  output logic             pwr_valid,
  output logic             ovf_flag
);
  logic [LO_W-1:0] lo_q, lo_sum, nxt_lo;
  logic [HI_W-1:0] hi_q, nxt_hi;
  logic            ovf_q, lo_cout, hi_wrap, sat;
  logic [LO_W-1:0] addend_ext;

  assign addend_ext = LO_W'(addend);

  pwri_cla #(.W(LO_W)) i_cla (
    .a    (lo_q),
    .b    (addend_ext),
    .cin  (1'b0),
    .sum  (lo_sum),
    .cout (lo_cout)
  );

  assign hi_wrap = lo_cout & (&hi_q);
  assign sat     = ovf_q | hi_wrap;

  always_comb begin
    if (sat) begin
      nxt_lo = '1;
      nxt_hi = '1;
    end else begin
      nxt_lo = lo_sum;
      nxt_hi = lo_cout ? hi_q + HI_W'(1) : hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= '0;
      ovf_q     <= 1'b0;
      pwr_word  <= '0;
      pwr_valid <= 1'b0;
      ovf_flag  <= 1'b0;
    end else if (flush) begin
      lo_q      <= '0;
      hi_q      <= '0;
      ovf_q     <= 1'b0;
      pwr_valid <= 1'b0;
    end else begin
      pwr_valid <= add_en & close;
      if (add_en) begin
        if (close) begin
          lo_q     <= '0;
          hi_q     <= '0;
          ovf_q    <= 1'b0;
          pwr_word <= {nxt_hi, nxt_lo};
          ovf_flag <= sat;
        end else begin
          lo_q  <= nxt_lo;
          hi_q  <= nxt_hi;
          ovf_q <= sat;
        end
      end
    end
  end

  // R7
  sat_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_valid && ovf_flag) |-> (&pwr_word));
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_valid |-> ($stable(pwr_word) && $stable(ovf_flag)));
endmodule

// File: rtl/pwr_integrator.sv
module pwr_integrator #(
  parameter int          SMP_W       = 6,
  parameter int          LO_W        = 12,
  parameter int          HI_W        = 20,
  parameter int          LEN_W       = 32,
  parameter int unsigned DEFAULT_WIN = 20_000_000,
  localparam int SUM_W = LO_W + HI_W,
  localparam int SQ_W  = 2 * SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enable,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [LEN_W-1:0] win_len,
  output logic [SUM_W-1:0] pwr_word,
  output logic             pwr_valid,
  output logic             ovf_flag
);
  logic            flush;
  logic            close;
  logic            sq_valid;
  logic [SQ_W-1:0] sq_data;

  pwri_ctrl #(.LEN_W(LEN_W), .DEFAULT_WIN(DEFAULT_WIN)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .enable   (enable),
    .sq_valid (sq_valid),
    .win_len  (win_len),
    .flush    (flush),
    .close    (close)
  );

  pwri_squarer #(.SMP_W(SMP_W), .SQ_W(SQ_W)) i_sq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .in_valid (smp_valid),
    .in_data  (smp_data),
    .sq_valid (sq_valid),
    .sq_data  (sq_data)
  );

  pwri_accum #(.LO_W(LO_W), .HI_W(HI_W), .SQ_W(SQ_W)) i_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .add_en    (sq_valid),
    .close     (close),
    .addend    (sq_data),
    .pwr_word  (pwr_word),
    .pwr_valid (pwr_valid),
    .ovf_flag  (ovf_flag)
  );

  // R8
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pwr_valid);
  // R9
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pwr_valid);
  // R4
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_valid |-> $past(sq_valid));
endmodule

// File: tb/test_pwr_integrator.sv
module test_pwr_integrator;
  localparam int CLK_PERIOD = 10;
  localparam int SMP_W = 6;
  localparam int LO_W  = 12;
  localparam int HI_W  = 8;
  localparam int LEN_W = 32;
  localparam int DEFW  = 5;
  localparam int SUM_W = LO_W + HI_W;
  localparam longint MAXV = (longint'(1) << SUM_W) - 1;
  localparam int WATCHDOG = 100000;

  logic             clk, rst_n, clr, enable, smp_valid;
  logic [SMP_W-1:0] smp_data;
  logic [LEN_W-1:0] win_len;
  logic [SUM_W-1:0] pwr_word;
  logic             pwr_valid, ovf_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  string tag   = "R1";

  pwr_integrator #(.SMP_W(SMP_W), .LO_W(LO_W), .HI_W(HI_W), .LEN_W(LEN_W),
                   .DEFAULT_WIN(DEFW)) i_pwr_integrator (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enable(enable),
    .smp_valid(smp_valid), .smp_data(smp_data), .win_len(win_len),
    .pwr_word(pwr_word), .pwr_valid(pwr_valid), .ovf_flag(ovf_flag));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit     m_run, p_v, m_valid, m_ovf, m_ovfo;
  longint m_sum, m_word, p_sq, s;
  int     m_win, m_cnt, x;
  bit     o;

  function automatic int eff(logic [LEN_W-1:0] l);
    return (l == 0) ? DEFW : int'(l);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; p_v = 0; p_sq = 0; m_valid = 0; m_ovf = 0; m_ovfo = 0;
      m_sum = 0; m_word = 0; m_win = 0; m_cnt = 0;
    end else if (clr || !enable) begin
      m_run = 0; p_v = 0; m_cnt = 0; m_sum = 0; m_ovf = 0; m_valid = 0;
    end else begin
      m_valid = 0;
      if (p_v) begin
        s = m_sum + p_sq;
        o = m_ovf;
        if (s > MAXV) o = 1;
        if (o) s = MAXV;
        if (m_cnt == m_win - 1) begin
          m_word = s; m_valid = 1; m_ovfo = o;
          m_sum = 0; m_ovf = 0; m_cnt = 0; m_win = eff(win_len);
        end else begin
          m_sum = s; m_ovf = o; m_cnt++;
        end
      end
      if (!m_run) begin
        m_run = 1; m_win = eff(win_len); m_cnt = 0;
      end
      x = $signed(smp_data);
      p_v = smp_valid;
      p_sq = x * x;
    end
  end

  // per-clock comparison: strobe timing (R4), word (R2) and flag (R7)
  always @(negedge clk) begin
    if (rst_n) begin
      check({tag, " R4"}, "pwr_valid", pwr_valid, m_valid);
      check({tag, " R2"}, "pwr_word", pwr_word, m_word);
      check({tag, " R7"}, "ovf_flag", ovf_flag, m_ovfo);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic send(int v);
    smp_data = SMP_W'(v);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic restart(int len);
    enable = 1'b0;
    @(negedge clk);
    win_len = LEN_W'(len);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_result(string req, longint exp_w, bit exp_o);
    bit seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (pwr_valid) seen = 1;
      else @(negedge clk);
    end
    check(req, "result seen", seen, 1);
    if (seen) begin
      check(req, "result word", pwr_word, exp_w);
      check(req, "result ovf", ovf_flag, exp_o);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; enable = 1'b0; smp_valid = 1'b0;
    smp_data = '0; win_len = '0;
    repeat (3) @(negedge clk);
    check("R1", "word in reset", pwr_word, 0);
    check("R1", "valid in reset", pwr_valid, 0);
    check("R1", "ovf in reset", ovf_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", pwr_valid, 0);

    tag = "R2";
    restart(4);
    send(-32); send(31); send(0); send(-1);
    expect_result("R2", 1986, 0);

    tag = "R3";
    restart(3);
    send(5); repeat (3) @(negedge clk);
    send(-7); @(negedge clk);
    send(2);
    expect_result("R3", 78, 0);

    tag = "R5";
    restart(3);
    for (int i = 1; i <= 6; i++) send(i);
    repeat (4) @(negedge clk);
    check("R5", "last window word", pwr_word, 16 + 25 + 36);

    tag = "R6";
    restart(2);
    send(3); win_len = 5; send(4);
    expect_result("R6", 25, 0);
    repeat (5) send(1);
    expect_result("R6", 5, 0);

    tag = "R7";
    restart(1100);
    repeat (1100) send(-32);
    expect_result("R7", MAXV, 1);
    restart(2);
    send(1); send(1);
    expect_result("R7", 2, 0);

    tag = "R10";
    repeat (6) @(negedge clk);
    check("R10", "word held", pwr_word, 2);
    check("R10", "ovf held", ovf_flag, 0);

    tag = "R8";
    restart(4);
    send(5); send(5); send(5);
    enable = 1'b0; smp_data = 6'd9; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check("R8", "no strobe while disabled", pwr_valid, 0);
      @(negedge clk);
    end
    enable = 1'b1;
    @(negedge clk);
    repeat (4) send(2);
    expect_result("R8", 16, 0);

    tag = "R9";
    restart(3);
    send(7); send(7);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R9", "no strobe after clear", pwr_valid, 0);
    @(negedge clk);
    repeat (3) send(1);
    expect_result("R9", 3, 0);

    tag = "R11";
    restart(0);
    repeat (5) send(3);
    expect_result("R11", 45, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule